// File: doc/BRIEF.md
# Clock Chip Bring-Up Sequencer

This block configures an external clock-distribution device after reset, with no processor involved. On a start pulse it sends a fixed series of single-register transactions through a register-access port. The port is served by a separate serial-bus master. The series has these steps in order:

- Write a three-byte unlock key.
- Soft-reset the device and select the 4-wire serial mode.
- Copy a ready-made configuration image into the device one byte at a time.
- Poll two status registers until both PLLs report lock.
- Enable the sync reference by writing back two image bytes with a bit cleared in each.
- Write the key registers again to lock them.

The image sits in a small array outside the block and is read through a combinational address/data pair. Only one transaction is outstanding at a time. Each request is a one-cycle pulse, and the sequencer waits for the port's one-cycle acknowledge before it moves on. If lock is not seen within a programmable number of poll rounds, the sequencer stops and raises an error. Otherwise it ends with a done flag.

Top module: `clkchip_cfg_seq`

## Requirements
- R1: After reset, and after any reset applied mid-sequence, busy, done and error are 0 and no request is issued until the next start pulse.
- R2: A start pulse in the idle, done or error state sets busy in the following cycle. Busy stays high, with done and error low, until the sequence ends. A start pulse while busy has no effect on the transactions issued.
- R3: The first three transactions are writes of 0x00 to 0x1FFD, 0x00 to 0x1FFE and 0x53 to 0x1FFF, in that order.
- R4: These are followed by a write of 0x80 to address 0x000 and then a write of 0x10 to address 0x000.
- R5: Next come IMG_BYTES (default 117) writes. Write i sends image byte i to address 0x100 + i, with i ascending from 0.
- R6: Each poll round is a read of 0x182 followed by a read of 0x183. The round passes only if bit 1 is set in both returned bytes; all other bits are ignored. A failed round is followed by another round.
- R7: When the number of failed rounds reaches poll_limit (a limit of 0 acts as 1), error is set, busy falls and no further request is issued.
- R8: After a passing round, the block writes image byte 0x40 ANDed with 0xFB to address 0x140, then image byte 0x43 ANDed with 0x7F to address 0x143.
- R9: The sequence ends with writes of 0xFF to 0x1FFD, 0x1FFE and 0x1FFF, in that order, after which done is set.
- R10: A new request is never issued while the previous one has not been acknowledged.
- R11: Done and error hold their value, with no requests issued, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| poll_limit | input | POLL_W | Failed poll rounds allowed before error |
| img_addr | output | IMG_AW | Image byte index |
| img_data | input | 8 | Image byte at img_addr (combinational) |
| req | output | 1 | One-cycle transaction request |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_addr | output | 13 | Device register address |
| req_wdata | output | 8 | Write data |
| ack | input | 1 | One-cycle transaction done |
| ack_rdata | input | 8 | Read data, valid with ack |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| error | output | 1 | Lock poll timed out |

## Verification
A wrong phase or step index shows up at the request port on the very next request: a wrong address, a wrong data byte or a step out of order. The bench compares every logged transaction against the expected list, region by region. A wrong poll count or a misread lock bit changes the total number of poll reads and whether done or error ends the run, so it is visible once the poll rounds finish. A lost wait state shows as a second request before the acknowledge, and the responder model counts those.

// File: rtl/clkchip_cfg_pkg.sv
// Shared types and fixed device addresses for the bring-up sequencer.
// Assumes a 13-bit device register address and 8-bit register data.
package clkchip_cfg_pkg;
    localparam int REG_AW       = 13;
    localparam int REG_DW       = 8;
    localparam int PRE_STEPS    = 5;
    localparam int SYNC_STEPS   = 2;
    localparam int RELOCK_STEPS = 3;

    localparam logic [REG_AW-1:0] KEY_ADDR0   = 13'h1FFD;
    localparam logic [REG_AW-1:0] KEY_ADDR1   = 13'h1FFE;
    localparam logic [REG_AW-1:0] KEY_ADDR2   = 13'h1FFF;
    localparam logic [REG_AW-1:0] CTRL_ADDR   = 13'h000;
    localparam logic [REG_AW-1:0] LOAD_BASE   = 13'h100;
    localparam logic [REG_AW-1:0] STAT_ADDR_A = 13'h182;
    localparam logic [REG_AW-1:0] STAT_ADDR_B = 13'h183;
    localparam logic [REG_AW-1:0] SYNC_ADDR_A = 13'h140;
    localparam logic [REG_AW-1:0] SYNC_ADDR_B = 13'h143;

    localparam logic [REG_DW-1:0] UNLOCK_KEY  = 8'd83;
    localparam logic [REG_DW-1:0] SOFT_RESET  = 8'h80;
    localparam logic [REG_DW-1:0] MODE_4WIRE  = 8'h10;
    localparam logic [REG_DW-1:0] LOCK_KEY    = 8'hFF;
    localparam logic [REG_DW-1:0] SYNC_MASK_A = 8'hFB;
    localparam logic [REG_DW-1:0] SYNC_MASK_B = 8'h7F;

    typedef enum logic [3:0] {
        PH_IDLE, PH_PRE, PH_LOAD, PH_POLL_A, PH_POLL_B,
        PH_SYNC, PH_RELOCK, PH_DONE, PH_FAIL
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } txn_t;
endpackage

// File: rtl/clkchip_cfg_step_map.sv
// Decodes the current phase and step index into one device transaction.
// It also selects which image byte is needed. Purely combinational.
// Assumes img_data follows img_addr within the same cycle.
module clkchip_cfg_step_map
    import clkchip_cfg_pkg::*;
#(
    parameter int IMG_BYTES  = 117,
    parameter int IMG_AW     = 7,
    parameter int IDX_W      = 7,
    parameter int SYNC_OFS_A = 64,
    parameter int SYNC_OFS_B = 67
) (
    input  phase_e             phase,
    input  logic [IDX_W-1:0]   idx,
    input  logic [REG_DW-1:0]  img_data,
    output logic [IMG_AW-1:0]  img_addr,
    output txn_t               txn
);
    // Transaction decode per phase and step.
    always_comb begin
        txn      = '0;
        img_addr = '0;
        case (phase)
            PH_PRE: begin
                case (int'(idx))
                    0:       txn = '{1'b1, KEY_ADDR0, 8'h00};
                    1:       txn = '{1'b1, KEY_ADDR1, 8'h00};
                    2:       txn = '{1'b1, KEY_ADDR2, UNLOCK_KEY};
                    3:       txn = '{1'b1, CTRL_ADDR, SOFT_RESET};
                    default: txn = '{1'b1, CTRL_ADDR, MODE_4WIRE};
                endcase
            end
            PH_LOAD: begin
                img_addr = IMG_AW'(idx);
                txn      = '{1'b1, LOAD_BASE + REG_AW'(idx), img_data};
            end
            PH_POLL_A: txn = '{1'b0, STAT_ADDR_A, 8'h00};
            PH_POLL_B: txn = '{1'b0, STAT_ADDR_B, 8'h00};
            PH_SYNC: begin
                if (idx == '0) begin
                    img_addr = IMG_AW'(SYNC_OFS_A);
                    txn      = '{1'b1, SYNC_ADDR_A, img_data & SYNC_MASK_A};
                end else begin
                    img_addr = IMG_AW'(SYNC_OFS_B);
                    txn      = '{1'b1, SYNC_ADDR_B, img_data & SYNC_MASK_B};
                end
            end
            PH_RELOCK: txn = '{1'b1, KEY_ADDR0 + REG_AW'(idx), LOCK_KEY};
            default:   txn = '0;
        endcase
    end
endmodule

// File: rtl/clkchip_cfg_poll_ctr.sv
// Counts failed lock-poll rounds. Flags when the round being judged is
// the last one allowed. Assumes the limit is stable while polling.
module clkchip_cfg_poll_ctr #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bump,
    input  logic [POLL_W-1:0] limit,
    output logic              last
);
    logic [POLL_W-1:0] cnt_q;

    // Failed-round counter, cleared at each start.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (bump)   cnt_q <= cnt_q + 1'b1;
    end

    // A limit of zero behaves as one.
    assign last = ({1'b0, cnt_q} + (POLL_W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/clkchip_cfg_seq.sv
// Top of the bring-up sequencer. It walks the phases, issues one
// registered request at a time and waits for ack before advancing.
// Assumes ack comes at least one cycle after req and only as a reply to it.
module clkchip_cfg_seq
    import clkchip_cfg_pkg::*;
#(
    parameter int          IMG_BYTES  = 117,
    parameter int          POLL_W     = 16,
    parameter int          SYNC_OFS_A = 64,
    parameter int          SYNC_OFS_B = 67,
    parameter logic [7:0]  LOCK_MASK  = 8'h02,
    localparam int         IMG_AW     = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POLL_W-1:0] poll_limit,
    output logic [IMG_AW-1:0] img_addr,
    input  logic [7:0]        img_data,
    output logic              req,
    output logic              req_wr,
    output logic [12:0]       req_addr,
    output logic [7:0]        req_wdata,
    input  logic              ack,
    input  logic [7:0]        ack_rdata,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int IDX_W = $clog2(IMG_BYTES > PRE_STEPS ? IMG_BYTES : PRE_STEPS);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             wait_q, lock_a_q, req_q;
    txn_t             req_txn_q, cur_txn;
    logic             busy_w, poll_last, poll_fail, stat_ok, adv;

    assign busy_w  = !(phase_q inside {PH_IDLE, PH_DONE, PH_FAIL});
    assign stat_ok = (ack_rdata & LOCK_MASK) == LOCK_MASK;
    assign adv     = busy_w && wait_q && ack;

    clkchip_cfg_step_map #(
        .IMG_BYTES (IMG_BYTES),
        .IMG_AW    (IMG_AW),
        .IDX_W     (IDX_W),
        .SYNC_OFS_A(SYNC_OFS_A),
        .SYNC_OFS_B(SYNC_OFS_B)
    ) u_map (
        .phase   (phase_q),
        .idx     (idx_q),
        .img_data(img_data),
        .img_addr(img_addr),
        .txn     (cur_txn)
    );

    clkchip_cfg_poll_ctr #(.POLL_W(POLL_W)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(!busy_w && start),
        .bump (adv && poll_fail),
        .limit(poll_limit),
        .last (poll_last)
    );

    // Next phase and step once the current transaction is acknowledged.
    always_comb begin
        phase_d   = phase_q;
        idx_d     = idx_q + 1'b1;
        poll_fail = 1'b0;
        case (phase_q)
            PH_PRE:
                if (idx_q == IDX_W'(PRE_STEPS-1)) begin
                    phase_d = PH_LOAD;   idx_d = '0;
                end
            PH_LOAD:
                if (idx_q == IDX_W'(IMG_BYTES-1)) begin
                    phase_d = PH_POLL_A; idx_d = '0;
                end
            PH_POLL_A: begin
                phase_d = PH_POLL_B; idx_d = '0;
            end
            PH_POLL_B: begin
                idx_d = '0;
                if (lock_a_q && stat_ok) phase_d = PH_SYNC;
                else if (poll_last)      phase_d = PH_FAIL;
                else begin
                    phase_d   = PH_POLL_A;
                    poll_fail = 1'b1;
                end
            end
            PH_SYNC:
                if (idx_q == IDX_W'(SYNC_STEPS-1)) begin
                    phase_d = PH_RELOCK; idx_d = '0;
                end
            PH_RELOCK:
                if (idx_q == IDX_W'(RELOCK_STEPS-1)) begin
                    phase_d = PH_DONE;   idx_d = '0;
                end
            default: phase_d = phase_q;
        endcase
    end

    // Phase, step and request register; one request in flight at most.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            idx_q     <= '0;
            wait_q    <= 1'b0;
            req_q     <= 1'b0;
            req_txn_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (!busy_w) begin
                if (start) begin
                    phase_q <= PH_PRE;
                    idx_q   <= '0;
                    wait_q  <= 1'b0;
                end
            end else if (!wait_q) begin
                req_q     <= 1'b1;
                req_txn_q <= cur_txn;
                wait_q    <= 1'b1;
            end else if (ack) begin
                wait_q  <= 1'b0;
                phase_q <= phase_d;
                idx_q   <= idx_d;
            end
        end
    end

    // Lock result of the first status read of a round.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_a_q <= 1'b0;
        else if (adv && phase_q == PH_POLL_A) lock_a_q <= stat_ok;
    end

    assign req       = req_q;
    assign req_wr    = req_txn_q.wr;
    assign req_addr  = req_txn_q.addr;
    assign req_wdata = req_txn_q.data;
    assign busy      = busy_w;
    assign done      = phase_q == PH_DONE;
    assign error     = phase_q == PH_FAIL;
endmodule

// File: rtl/clkchip_cfg_seq_chk.sv
// Port-level protocol checks for the bring-up sequencer, bound to the top.
module clkchip_cfg_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        req,
    input logic        req_wr,
    input logic [12:0] req_addr,
    input logic        ack,
    input logic        busy,
    input logic        done,
    input logic        error
);
    logic outstanding;

    // Tracks a request that has not been acknowledged yet.
    always_ff @(posedge clk) begin
        if (!rst_n)   outstanding <= 1'b0;
        else if (req) outstanding <= 1'b1;
        else if (ack) outstanding <= 1'b0;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done, error}) <= 1); // R2
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy); // R2
    AST_SINGLE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !outstanding); // R10
    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !req); // R7
    AST_DONE_AFTER_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (req_wr && req_addr == 13'h1FFF)); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R11
    AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error); // R11
endmodule

bind clkchip_cfg_seq clkchip_cfg_seq_chk u_chk (.*);

// File: tb/sim_clkchip_cfg_seq.sv
module sim_clkchip_cfg_seq;
    localparam int NB = 117;
    localparam int NS = 7;
    // limit, failing rounds, mode (0 both,1 B only,2 A only unlocked), ack delay, seed
    localparam int SCN [NS][5] = '{
        '{4, 0, 0, 1, 5},
        '{4, 2, 0, 2, 11},
        '{3, 2, 1, 1, 23},
        '{5, 1, 2, 3, 7},
        '{2, 2, 0, 1, 3},
        '{0, 1, 0, 2, 9},
        '{1, 0, 0, 1, 17}
    };

    logic clk = 0, rst_n = 0, start = 0, ack = 0;
    logic [15:0] poll_limit = 16'd4;
    logic [6:0]  img_addr;
    logic [7:0]  img_data, ack_rdata = 0, req_wdata;
    logic        req, req_wr, busy, done, error;
    logic [12:0] req_addr;
    logic [7:0]  img [0:NB-1];
    logic [21:0] log_q [0:511];
    int log_n = 0, overlap = 0, pairs = 0, mode = 0, nfail = 0, delay = 1;
    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    assign img_data = (int'(img_addr) < NB) ? img[img_addr] : 8'h00;

    clkchip_cfg_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
        .img_addr(img_addr), .img_data(img_data), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
        .ack_rdata(ack_rdata), .busy(busy), .done(done), .error(error)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Register-port responder: logs requests, acks after delay, models lock status.
    initial begin
        int cnt = 0;
        bit pend = 0;
        logic [12:0] a = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 0; ack = 0; cnt = 0;
            end else begin
                if (ack) ack = 0;
                if (req) begin
                    if (pend) overlap++;
                    if (log_n < 512) log_q[log_n] = {req_wr, req_addr, req_wr ? req_wdata : 8'h00};
                    log_n++;
                    pend = 1; cnt = delay; a = req_addr;
                end else if (pend) begin
                    cnt--;
                    if (cnt <= 0) begin
                        pend = 0; ack = 1;
                        if (a == 13'h182)
                            ack_rdata = (pairs < nfail && mode != 1) ? 8'hFD : 8'h02;
                        else if (a == 13'h183) begin
                            ack_rdata = (pairs < nfail && mode != 2) ? 8'hFD : 8'h02;
                            pairs++;
                        end else ack_rdata = 8'h5A;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d expected <150000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    function automatic logic [21:0] exp_at(int k, int np);
        int r;
        if (k == 0) return {1'b1, 13'h1FFD, 8'h00};
        if (k == 1) return {1'b1, 13'h1FFE, 8'h00};
        if (k == 2) return {1'b1, 13'h1FFF, 8'h53};
        if (k == 3) return {1'b1, 13'h000, 8'h80};
        if (k == 4) return {1'b1, 13'h000, 8'h10};
        if (k < 5 + NB) return {1'b1, 13'(16'h100 + k - 5), img[k-5]};
        r = k - 5 - NB;
        if (r < 2*np) return (r % 2 == 0) ? {1'b0, 13'h182, 8'h00} : {1'b0, 13'h183, 8'h00};
        r = r - 2*np;
        if (r == 0) return {1'b1, 13'h140, img[64] & 8'hFB};
        if (r == 1) return {1'b1, 13'h143, img[67] & 8'h7F};
        return {1'b1, 13'(16'h1FFD + r - 2), 8'hFF};
    endfunction

    task automatic check_range(string tag, int lo, int hi, int np);
        int bad = -1;
        for (int k = lo; k < hi; k++)
            if (bad < 0 && (k >= log_n || log_q[k] !== exp_at(k, np))) bad = k;
        if (bad < 0) chk(1, tag, "sequence", 0, 0);
        else chk(0, tag, $sformatf("txn %0d", bad),
                 bad < log_n ? int'(log_q[bad]) : -1, int'(exp_at(bad, np)));
    endtask

    task automatic run_scn(int s);
        int lim, np, n_exp, cyc, n0;
        bit err;
        lim = SCN[s][0]; nfail = SCN[s][1]; mode = SCN[s][2]; delay = SCN[s][3];
        poll_limit = 16'(lim);
        for (int i = 0; i < NB; i++) img[i] = 8'((i * 37 + SCN[s][4]) & 8'hFF);
        err = nfail >= ((lim < 1) ? 1 : lim);
        np  = err ? ((lim < 1) ? 1 : lim) : nfail + 1;
        n_exp = 5 + NB + 2*np + (err ? 0 : 5);
        pairs = 0; log_n = 0; overlap = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy && !done && !error, "R2", $sformatf("scn %0d busy after start", s),
            {busy, done, error}, 3'b100);
        cyc = 0;
        while (!(done || error) && cyc < 5000) begin
            @(negedge clk); cyc++;
            start = (s == 1 && cyc == 40);
        end
        start = 0;
        chk(log_n == n_exp, err ? "R7" : "R6", $sformatf("scn %0d txn count", s), log_n, n_exp);
        check_range("R3", 0, 3, np);
        check_range("R4", 3, 5, np);
        check_range("R5", 5, 5 + NB, np);
        check_range("R6", 5 + NB, 5 + NB + 2*np, np);
        if (err)
            chk(error && !done && !busy, "R7", $sformatf("scn %0d flags", s), {busy, done, error}, 3'b001);
        else begin
            check_range("R8", 5 + NB + 2*np, 7 + NB + 2*np, np);
            check_range("R9", 7 + NB + 2*np, n_exp, np);
            chk(done && !error && !busy, "R9", $sformatf("scn %0d flags", s), {busy, done, error}, 3'b010);
        end
        if (s == 1) chk(log_n == n_exp, "R2", "start while busy ignored", log_n, n_exp);
        chk(overlap == 0, "R10", $sformatf("scn %0d overlap", s), overlap, 0);
        n0 = log_n;
        repeat (5) @(negedge clk);
        chk(log_n == n0 && (err ? error : done), "R11", $sformatf("scn %0d hold", s), log_n, n0);
    endtask

    initial begin
        int n0;
        for (int i = 0; i < NB; i++) img[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !req, "R1", "reset state", {busy, done, error, req}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(log_n == 0 && !busy, "R1", "idle without start", log_n, 0);

        for (int s = 0; s < NS; s++) run_scn(s);

        // Reset in the middle of the image load.
        poll_limit = 16'd4; nfail = 0; mode = 0; delay = 1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (30) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !error, "R1", "mid-run reset flags", {busy, done, error}, 0);
        rst_n = 1;
        n0 = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == n0 && !busy, "R1", "quiet after reset", log_n, n0);
        run_scn(0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule